// File: doc/BRIEF.md
# Scan data FIFO pair with retiming compensation

This block sits between an 8-bit host byte path and a serial test-scan path. The host loads bytes into a small transmit queue; during a scan each byte is sent bit by bit, least significant bit first, on the serial output at each falling-edge strobe of the test clock. Returned serial data is sampled at each rising-edge strobe, packed back into bytes and stored in a receive queue that the host drains.

Targets reached through pipeline stages return their data late. The block takes a retiming depth of 0 to 15 test-clock cycles with each scan. It throws away that many early samples and keeps sampling for the same number of extra rising edges after the last bit is sent, so received bytes line up with the transmitted ones. The test-clock generator supplies the edge strobes and marks the last bit of a scan; the block reports when the scan has drained.

Besides full-duplex scans there are input-only, output-only and recirculate scans, and two loopback modes in which the receive path captures the block's own serial output or the mode-select line.

Top module: `scan_fifo_pair`

## Requirements
- R1: After reset, `tx_full` is 0, `rx_empty` is 1, `busy` is 0 and `tdo` is 1.
- R2: The transmit queue holds 4 bytes. `tx_full` is 1 while it holds 4. A write while `tx_full` is 1 is discarded, and that byte is never sent.
- R3: A `start` pulse empties the transmit queue. `tx_full` reads 1 in the cycle after `start`, and writes in that cycle are discarded. Bytes written before `start` are never sent.
- R4: In modes that send queued data, each `tck_fall` strobe sets `tdo` to the next queued bit, least significant bit first. If no queued bit is left, `tdo` is 1.
- R5: Each `tck_rise` strobe samples one bit, and every 8 kept bits form one byte (first kept bit in bit 0). `rx_empty` is 1 exactly when no byte is queued. `rd_data` shows the oldest byte, and `rd_en` removes it.
- R6: With retiming depth D (modes 0, 1 and 3), the first D samples are discarded. Sampling continues for D rising edges after the edge of the last bit, so `busy` falls after rising edge L+D of an L-bit scan, and the received bytes equal the transmitted ones.
- R7: At scan end, a partial final byte of n bits is queued right-justified, with zeros in bits 7..n.
- R8: Mode 1 (input only) holds `tdo` at 1 and takes no bytes from the transmit queue.
- R9: Mode 2 (output only) queues no received byte.
- R10: In mode 3 (recirculate), `tdo` after each `tck_fall` equals the bit sampled at the previous `tck_rise`. The first bit of a scan is 1. Samples are also captured.
- R11: In mode 4, the receive path captures the bit on `tdo` itself with no retiming discard, so the host reads back the bytes it sent.
- R12: In mode 5, the receive path captures `tms_in` at each rising strobe with no retiming discard, while queued data is still sent. Mode 0 is full duplex, and codes 6 and 7 act as mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a scan; latches `mode` and `delay`, empties transmit queue |
| mode | input | 3 | Scan mode code (see R8 to R12) |
| delay | input | 4 | Retiming depth in test-clock cycles |
| tck_fall | input | 1 | Falling test-clock edge strobe: launch a bit |
| tck_rise | input | 1 | Rising test-clock edge strobe: sample a bit |
| last_bit | input | 1 | With `tck_fall`, marks the final bit of the scan |
| tdi | input | 1 | Returned serial data |
| tms_in | input | 1 | Mode-select stream, for loopback mode 5 |
| wr_en | input | 1 | Push `wr_data` into the transmit queue |
| wr_data | input | 8 | Byte to send |
| rd_en | input | 1 | Pop the oldest received byte |
| rd_data | output | 8 | Oldest received byte |
| tx_full | output | 1 | Transmit queue full or being emptied |
| rx_empty | output | 1 | Receive queue empty |
| busy | output | 1 | Scan in progress, including the retiming tail |
| tdo | output | 1 | Serial data out |

## Verification
Each scan sends a fixed data word to a modelled target that echoes it back after D rising edges, or that returns the same word as a pattern in the input-only and recirculate modes. The host bytes must therefore come back unchanged. Retiming depths 0, 1, 5 and 15 are used, so a wrong discard count or tail length shows up as a shifted byte or a wrong count of tail edges. Scan lengths of 9, 12, 13 and 20 bits separate correct right-justification of the last byte from left-packed or unpadded bytes. The loopback runs use a nonzero depth and a junk input, so they show whether the capture source and the discard rule follow the mode. Directed runs check what happens when the transmit queue is filled, flushed and starved.

// File: rtl/scan_fifo_pair.sv
module scan_fifo_pair #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  parameter int DLYW  = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [2:0]   mode,
  input  logic [DLYW-1:0] delay,
  input  logic         tck_fall,
  input  logic         tck_rise,
  input  logic         last_bit,
  input  logic         tdi,
  input  logic         tms_in,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         tx_full,
  output logic         rx_empty,
  output logic         busy,
  output logic         tdo
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] WFULL = CW'(W);
  localparam logic [AW:0]   DFULL = (AW+1)'(DEPTH);
  localparam logic [2:0] M_FULL = 3'd0, M_IN = 3'd1, M_OUT = 3'd2,
                         M_RECIRC = 3'd3, M_LB_DATA = 3'd4, M_LB_SEL = 3'd5;

  logic [W-1:0]    tx_mem [DEPTH];
  logic [W-1:0]    rx_mem [DEPTH];
  logic [AW:0]     tx_wp, tx_rp, rx_wp, rx_rp, tx_cnt, rx_cnt;
  logic            flushing, active, launching, fin, rec_q;
  logic [2:0]      mode_q;
  logic [DLYW-1:0] dly_q, skip, tail, dly_in;
  logic [W-1:0]    txsr, rxsr, tx_head, nsr, rx_pdata;
  logic [CW-1:0]   txbits, rxbits, nbits;
  logic            tx_empty, rx_full, uses_tx, captures;
  logic            launch, sample, cap, done, tx_push, tx_pop, rx_push, rx_pop;
  logic            src, next_tdo;

  assign tx_cnt   = tx_wp - tx_rp;
  assign rx_cnt   = rx_wp - rx_rp;
  assign tx_empty = (tx_wp == tx_rp);
  assign rx_empty = (rx_wp == rx_rp);
  assign rx_full  = (rx_cnt == DFULL);
  assign tx_full  = (tx_cnt == DFULL) | flushing;
  assign tx_head  = tx_mem[tx_rp[AW-1:0]];
  assign rd_data  = rx_mem[rx_rp[AW-1:0]];
  assign busy     = active;

  assign uses_tx  = !(mode_q == M_IN || mode_q == M_RECIRC);
  assign captures = (mode_q != M_OUT);
  assign dly_in   = (mode == M_OUT || mode == M_LB_DATA || mode == M_LB_SEL) ? '0 : delay;

  assign launch  = tck_fall & active & launching & !start;
  assign sample  = tck_rise & active & !start;
  assign tx_push = wr_en & !tx_full & !start;
  assign tx_pop  = launch & uses_tx & (txbits == '0) & !tx_empty;
  assign rx_pop  = rd_en & !rx_empty;

  assign src   = (mode_q == M_LB_DATA) ? tdo : (mode_q == M_LB_SEL) ? tms_in : tdi;
  assign cap   = sample & captures & (skip == '0);
  assign nsr   = {src, rxsr[W-1:1]};
  assign nbits = rxbits + 1'b1;
  assign done  = sample & fin & (tail == '0);

  always_comb begin
    rx_push  = 1'b0;
    rx_pdata = nsr;
    if (cap && nbits == WFULL) begin
      rx_push = 1'b1;
    end else if (done && captures) begin
      if (cap) begin
        rx_push  = 1'b1;
        rx_pdata = nsr >> (WFULL - nbits);
      end else if (rxbits != '0) begin
        rx_push  = 1'b1;
        rx_pdata = rxsr >> (WFULL - rxbits);
      end
    end
  end

  always_comb begin
    if (mode_q == M_IN)          next_tdo = 1'b1;
    else if (mode_q == M_RECIRC) next_tdo = rec_q;
    else if (txbits != '0)       next_tdo = txsr[0];
    else if (!tx_empty)          next_tdo = tx_head[0];
    else                         next_tdo = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp[AW-1:0]] <= wr_data;
    if (rx_push && !rx_full) rx_mem[rx_wp[AW-1:0]] <= rx_pdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; rx_wp <= '0; rx_rp <= '0;
      flushing <= 1'b0; active <= 1'b0; launching <= 1'b0; fin <= 1'b0;
      rec_q <= 1'b1; tdo <= 1'b1; mode_q <= M_FULL;
      dly_q <= '0; skip <= '0; tail <= '0;
      txsr <= '0; rxsr <= '0; txbits <= '0; rxbits <= '0;
    end else begin
      flushing <= start;
      if (start) begin
        tx_wp <= '0;
        tx_rp <= '0;
      end else begin
        if (tx_push) tx_wp <= tx_wp + 1'b1;
        if (tx_pop)  tx_rp <= tx_rp + 1'b1;
      end
      if (rx_push && !rx_full) rx_wp <= rx_wp + 1'b1;
      if (rx_pop)              rx_rp <= rx_rp + 1'b1;

      if (start) begin
        active <= 1'b1; launching <= 1'b1; fin <= 1'b0;
        mode_q <= mode; dly_q <= dly_in; skip <= dly_in; tail <= '0;
        txbits <= '0; rxbits <= '0; rxsr <= '0;
        tdo <= 1'b1; rec_q <= 1'b1;
      end else begin
        if (launch) begin
          tdo <= next_tdo;
          if (tx_pop) begin
            txsr   <= tx_head >> 1;
            txbits <= WFULL - 1'b1;
          end else if (uses_tx && txbits != '0) begin
            txsr   <= txsr >> 1;
            txbits <= txbits - 1'b1;
          end
          if (last_bit) begin
            launching <= 1'b0;
            fin       <= 1'b1;
            tail      <= dly_q;
          end
        end
        if (sample) begin
          rec_q <= tdi;
          if (captures && skip != '0) skip <= skip - 1'b1;
          if (cap) begin
            if (nbits == WFULL) rxbits <= '0;
            else begin
              rxsr   <= nsr;
              rxbits <= nbits;
            end
          end
          if (fin) begin
            if (tail == '0) begin
              active <= 1'b0;
              fin    <= 1'b0;
              rxbits <= '0;
            end else begin
              tail <= tail - 1'b1;
            end
          end
        end
      end
    end
  end

  a_r3_flush_flag: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> tx_full);

  a_r2_full_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && tx_full && !start) |=> $stable(tx_wp));

  a_r8_input_only_high: assert property (@(posedge clk) disable iff (!rst_n)
    (active && mode_q == M_IN) |-> tdo);

  a_r9_output_only_no_rx: assert property (@(posedge clk) disable iff (!rst_n)
    (active && mode_q == M_OUT && !start) |=> $stable(rx_wp));

  a_r6_end_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> $past(tck_rise));

  a_r5_rx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= DFULL);
endmodule

// File: tb/scan_fifo_pair_tb_top.sv
module scan_fifo_pair_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0, start = 1'b0, tck_fall = 1'b0, tck_rise = 1'b0, last_bit = 1'b0;
  logic       tdi = 1'b1, tms_in = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] mode = 3'd0;
  logic [3:0] delay = 4'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] rd_data;
  logic       tx_full, rx_empty, busy, tdo;

  int checks = 0, failures = 0;

  scan_fifo_pair dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .delay(delay),
    .tck_fall(tck_fall), .tck_rise(tck_rise), .last_bit(last_bit),
    .tdi(tdi), .tms_in(tms_in), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .tx_full(tx_full),
    .rx_empty(rx_empty), .busy(busy), .tdo(tdo)
  );

  // {mode[47:45], delay[44:41], len[40:35], pad[34:32], data[31:0]}
  localparam logic [47:0] VEC [9] = '{
    {3'd0, 4'd0,  6'd16, 3'd0, 32'h0000_A53C},
    {3'd0, 4'd5,  6'd24, 3'd0, 32'h00C3_5A96},
    {3'd0, 4'd15, 6'd20, 3'd0, 32'h0009_1E2D},
    {3'd0, 4'd1,  6'd32, 3'd0, 32'hDEAD_BEEF},
    {3'd1, 4'd3,  6'd13, 3'd0, 32'h0000_1B6D},
    {3'd2, 4'd6,  6'd16, 3'd0, 32'h0000_7E81},
    {3'd3, 4'd2,  6'd12, 3'd0, 32'h0000_0A5C},
    {3'd4, 4'd9,  6'd10, 3'd0, 32'h0000_02F3},
    {3'd5, 4'd4,  6'd9,  3'd0, 32'h0000_0155}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_start(input logic [2:0] m, input logic [3:0] d);
    @(negedge clk);
    mode = m; delay = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wr_byte(input logic [7:0] b);
    wr_en = 1'b1; wr_data = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic fall(input logic last, output logic v);
    tck_fall = 1'b1; last_bit = last;
    @(negedge clk);
    tck_fall = 1'b0; last_bit = 1'b0;
    v = tdo;
  endtask

  task automatic rise(input logic t, input logic s);
    tdi = t; tms_in = s; tck_rise = 1'b1;
    @(negedge clk);
    tck_rise = 1'b0;
  endtask

  function automatic logic dbit(input logic [31:0] dat, input int idx);
    return (idx >= 0 && idx < 32) ? dat[idx] : 1'b1;
  endfunction

  task automatic run_scan(input logic [2:0] m, input logic [3:0] d, input int len,
                          input logic [31:0] dat, input int nw);
    int effd, pos, n, nb;
    logic prev, tv, ex, tb;
    logic [7:0] expb;
    string rtag;
    effd = (m == 3'd2 || m == 3'd4 || m == 3'd5) ? 0 : int'(d);
    rtag = (m == 3'd1) ? "R8" : (m == 3'd3) ? "R10" : (m == 3'd4) ? "R11" :
           (m == 3'd5) ? "R12" : "R6";
    do_start(m, d);
    @(negedge clk);
    for (int i = 0; i < nw; i++) wr_byte(dat[8*i +: 8]);
    prev = 1'b1;
    pos = 0;
    for (int k = 1; k <= len; k++) begin
      fall(k == len, tv);
      ex = (m == 3'd1) ? 1'b1 : (m == 3'd3) ? prev : dat[k-1];
      chk(tv === ex, (m == 3'd1) ? "R8 tdo" : (m == 3'd3) ? "R10 tdo" : "R4 tdo", tv, ex);
      tb = dbit(dat, k - 1 - int'(d));
      rise(tb, dat[k-1]);
      prev = tb;
      pos = k;
    end
    n = 0;
    while (busy && n < 40) begin
      pos++;
      rise(dbit(dat, pos - 1 - int'(d)), 1'b0);
      n++;
    end
    chk(n == effd, "R6 tail edges", n, effd);
    if (m != 3'd2) begin
      nb = (len + 7) / 8;
      for (int i = 0; i < nb; i++) begin
        expb = dat[8*i +: 8];
        if (8*i + 8 > len) expb = expb & 8'((1 << (len - 8*i)) - 1);
        chk(!rx_empty, "R5 byte present", rx_empty, 0);
        chk(rd_data === expb, (i == nb - 1 && len % 8 != 0) ? "R7 partial byte" : rtag, rd_data, expb);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
      end
      chk(rx_empty === 1'b1, "R5 empty after drain", rx_empty, 1);
    end else begin
      chk(rx_empty === 1'b1, "R9 no rx bytes", rx_empty, 1);
    end
    if (m == 3'd1) chk(tx_full === 1'b1, "R8 tx not consumed", tx_full, 1);
  endtask

  initial begin
    #1_000_000;
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic tv;
    logic [31:0] w;
    repeat (3) @(negedge clk);
    chk(tx_full === 1'b0, "R1 tx_full", tx_full, 0);
    chk(rx_empty === 1'b1, "R1 rx_empty", rx_empty, 1);
    chk(busy === 1'b0, "R1 busy", busy, 0);
    chk(tdo === 1'b1, "R1 tdo", tdo, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx_full === 1'b0 && rx_empty === 1'b1 && busy === 1'b0 && tdo === 1'b1,
        "R1 after release", {tx_full, rx_empty, busy, tdo}, 4'b0101);

    for (int v = 0; v < 9; v++) begin
      logic [2:0] m;
      int len, nw;
      m   = VEC[v][47:45];
      len = int'(VEC[v][40:35]);
      nw  = (m == 3'd1) ? 4 : (m == 3'd3) ? 0 : (len + 7) / 8;
      run_scan(m, VEC[v][44:41], len, VEC[v][31:0], nw);
    end

    // R3: bytes written before start are flushed
    wr_byte(8'h00);
    wr_byte(8'h00);
    do_start(3'd2, 4'd0);
    chk(tx_full === 1'b1, "R3 flag during flush", tx_full, 1);
    @(negedge clk);
    chk(tx_full === 1'b0, "R3 flag after flush", tx_full, 0);
    for (int k = 1; k <= 8; k++) begin
      fall(k == 8, tv);
      chk(tv === 1'b1, "R3 flushed data not sent", tv, 1);
      rise(1'b1, 1'b0);
    end
    chk(busy === 1'b0, "R6 output-only ends", busy, 0);

    // R2: full queue drops the fifth byte; R4: starved output is 1
    do_start(3'd2, 4'd0);
    @(negedge clk);
    wr_byte(8'h11); wr_byte(8'h22); wr_byte(8'h33);
    chk(tx_full === 1'b0, "R2 not full at 3", tx_full, 0);
    wr_byte(8'h44);
    chk(tx_full === 1'b1, "R2 full at 4", tx_full, 1);
    wr_byte(8'h55);
    w = 32'h4433_2211;
    for (int k = 1; k <= 40; k++) begin
      fall(k == 40, tv);
      if (k <= 32) chk(tv === w[k-1], "R2 queued bits", tv, w[k-1]);
      else         chk(tv === 1'b1, "R4 starved bit / R2 dropped byte", tv, 1);
      rise(1'b0, 1'b0);
    end
    chk(busy === 1'b0 && rx_empty === 1'b1, "R9 after output-only", {busy, rx_empty}, 2'b01);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule